// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns a system clock into the time grid of a CAN bit. One packed timing word sets the prescaler (system clocks per time quantum), the lengths of the two phase segments and the resynchronisation jump width, and it can turn on a three-sample majority vote. The block produces a one-clock pulse at the end of every time quantum, a sample strobe at the end of phase segment 1, and a transmit-point strobe at the end of each bit. It also produces the sampled bit value.

The timing word can only be written while a change-configuration request is granted. While the grant is held the bit timer stops. After the grant drops, the first recessive-to-dominant transition on the receive line hard-synchronises the timer. Later transitions of the same polarity resynchronise it: an edge in phase segment 1 stretches that segment, and an edge in phase segment 2 cuts that segment short. The amount is limited by the jump width. A frame engine uses the strobes to sample and to drive bits.

Top module: `can_bit_timer`

## Requirements
- R1: `cfg_granted` equals the value `cfg_req` had one clock earlier, both when the request rises and when it falls.
- R2: A write (`cfg_we`) takes effect only in a cycle where `cfg_granted` is high. A write in any other cycle leaves the bit timing unchanged.
- R3: Timing word encoding. Bits [2:0] hold TS2-1 (1..8 quanta). Bits [6:3] hold TS1-1 (1..16). Bit 7 enables triple sampling. Bits [9:8] hold SJW-1 (1..4). Bits [23:16] hold BRP-1 (1..256 clocks per quantum). All other bits are ignored. The value after reset is all zeros.
- R4: While the timer runs, `tq_tick` pulses for one clock every BRP clocks, so there are 1+TS1+TS2 pulses per bit. No pulse occurs while idle or while a grant has been held for more than one clock.
- R5: Hard sync. Let clock 1 be the first rising clock edge that sees `rx_in` low after `rx_in` was high and the grant was released. The first `sample_stb` is then visible after clock (1+TS1)*BRP.
- R6: Without resynchronisation, `tx_stb` is visible after clock (1+TS1+TS2)*BRP. `sample_stb` and `tx_stb` then repeat every (1+TS1+TS2)*BRP clocks.
- R7: A falling edge seen while the timer is in phase-1 quantum q (0-based) lengthens phase 1 of that bit by min(q+1, SJW) quanta.
- R8: A falling edge seen while the timer is in phase-2 quantum q (0-based) shortens phase 2 of that bit by min(TS2-1-q, SJW) quanta.
- R9: Only one falling edge per bit is used. The bit started by a hard sync takes no resynchronisation, and an edge in the sync quantum changes no timing.
- R10: `rx_bit` is updated one clock after `sample_stb`. With single sampling it takes the value `rx_in` had in the `sample_stb` cycle.
- R11: Triple sampling applies only when bit 7 is set and BRP > 4. `rx_bit` then becomes the majority of `rx_in` at the ends of the sample quantum and the two quanta before it. Otherwise single sampling applies.
- R12: After reset: `cfg_granted`, `tq_tick`, `sample_stb` and `tx_stb` are low, and `rx_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req | input | 1 | Change-configuration request |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_wdata | input | CFG_W | Timing word to write |
| rx_in | input | 1 | Receive line, 1 = recessive |
| cfg_granted | output | 1 | Request granted; timing may be written |
| tq_tick | output | 1 | End of a time quantum |
| sample_stb | output | 1 | Sample point, end of phase segment 1 |
| tx_stb | output | 1 | End of bit, transmit point for the next bit |
| rx_bit | output | 1 | Sampled bit value |

## Verification
A wrong quantum or segment counter shows up directly at the ports. The first `sample_stb` or `tx_stb` after a hard sync arrives too early or too late, so the error is visible within one bit time. A wrong resynchronisation computation, or wrong once-per-bit bookkeeping, moves the strobes of the following bit by whole quanta. Wrong sampling history or wrong majority logic shows up as a wrong `rx_bit` one clock after the sample point. The bench therefore measures strobe positions in clocks from the hard-sync edge, for several timing words and for edges shifted by one to three quanta.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  // raw field widths of the timing word
  localparam int BRP_W  = 8;
  localparam int TS1_W  = 4;
  localparam int TS2_W  = 3;
  localparam int SJW_W  = 2;
  // field positions inside the timing word
  localparam int TS2_LSB    = 0;
  localparam int TS1_LSB    = 3;
  localparam int TRIPLE_BIT = 7;
  localparam int SJW_LSB    = 8;
  localparam int BRP_LSB    = 16;
  // segment lengths in quanta: phase 1 may grow by the jump width
  localparam int TS1_MAX = 1 << TS1_W;
  localparam int SJW_MAX = 1 << SJW_W;
  localparam int LEN_W   = $clog2(TS1_MAX + SJW_MAX + 1);
  // prescaler minus one must reach this for majority voting
  localparam int TRIPLE_MIN_BRP_M1 = 4;

  typedef enum logic [1:0] {
    SEG_IDLE = 2'd0,
    SEG_SYNC = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;

  typedef struct packed {
    logic [BRP_W-1:0] brp_m1;
    logic [LEN_W-1:0] ts1;
    logic [LEN_W-1:0] ts2;
    logic [LEN_W-1:0] sjw;
    logic             triple;
  } timing_t;
endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg
  import can_bt_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_req,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             granted,
  output timing_t          timing
);
  logic             granted_q;
  logic [BRP_W-1:0] brp_q, brp_n;
  logic [TS1_W-1:0] ts1_q, ts1_n;
  logic [TS2_W-1:0] ts2_q, ts2_n;
  logic [SJW_W-1:0] sjw_q, sjw_n;
  logic             tri_q, tri_n;
  logic             wr_en;

  assign wr_en = cfg_we & granted_q;

  always_comb begin
    brp_n = brp_q;
    ts1_n = ts1_q;
    ts2_n = ts2_q;
    sjw_n = sjw_q;
    tri_n = tri_q;
    if (wr_en) begin
      brp_n = cfg_wdata[BRP_LSB +: BRP_W];
      ts1_n = cfg_wdata[TS1_LSB +: TS1_W];
      ts2_n = cfg_wdata[TS2_LSB +: TS2_W];
      sjw_n = cfg_wdata[SJW_LSB +: SJW_W];
      tri_n = cfg_wdata[TRIPLE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      granted_q <= 1'b0;
      brp_q     <= '0;
      ts1_q     <= '0;
      ts2_q     <= '0;
      sjw_q     <= '0;
      tri_q     <= 1'b0;
    end else begin
      granted_q <= cfg_req;
      brp_q     <= brp_n;
      ts1_q     <= ts1_n;
      ts2_q     <= ts2_n;
      sjw_q     <= sjw_n;
      tri_q     <= tri_n;
    end
  end

  assign granted       = granted_q;
  assign timing.brp_m1 = brp_q;
  assign timing.ts1    = LEN_W'(ts1_q) + LEN_W'(1);
  assign timing.ts2    = LEN_W'(ts2_q) + LEN_W'(1);
  assign timing.sjw    = LEN_W'(sjw_q) + LEN_W'(1);
  assign timing.triple = tri_q & (brp_q >= BRP_W'(TRIPLE_MIN_BRP_M1));
endmodule

// File: rtl/can_bt_presc.sv
module can_bt_presc
  import can_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [BRP_W-1:0] brp_m1,
  output logic             tick
);
  logic [BRP_W-1:0] cnt_q, cnt_n;
  logic             wrap;

  assign wrap = (cnt_q == brp_m1);

  always_comb begin
    if (!run)      cnt_n = '0;
    else if (wrap) cnt_n = '0;
    else           cnt_n = cnt_q + BRP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign tick = run & wrap;
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hold,
  input  logic    tick,
  input  logic    rx_in,
  input  timing_t timing,
  output logic    run,
  output logic    sample_pt,
  output logic    bit_end
);
  seg_e             seg_q, seg_n;
  logic [LEN_W-1:0] qc_q, qc_n;
  logic [LEN_W-1:0] len_q, len_n;
  logic             used_q, used_n;
  logic             prev_q;

  logic             fall, take, last;
  logic [LEN_W-1:0] late_err, ext, rem, shr, len_eff;

  assign fall     = prev_q & ~rx_in;
  assign take     = fall & ~used_q & (seg_q != SEG_IDLE);
  assign late_err = qc_q + LEN_W'(1);
  assign ext      = (late_err < timing.sjw) ? late_err : timing.sjw;
  assign rem      = len_q - LEN_W'(1) - qc_q;
  assign shr      = (rem < timing.sjw) ? rem : timing.sjw;

  always_comb begin
    len_eff = len_q;
    if (take && seg_q == SEG_PH1) len_eff = len_q + ext;
    if (take && seg_q == SEG_PH2) len_eff = len_q - shr;
  end

  assign last = (qc_q == len_eff - LEN_W'(1));

  always_comb begin
    seg_n  = seg_q;
    qc_n   = qc_q;
    len_n  = len_q;
    used_n = used_q;
    if (hold) begin
      seg_n  = SEG_IDLE;
      qc_n   = '0;
      len_n  = LEN_W'(1);
      used_n = 1'b0;
    end else if (seg_q == SEG_IDLE) begin
      if (fall) begin
        seg_n  = SEG_SYNC;
        qc_n   = '0;
        len_n  = LEN_W'(1);
        used_n = 1'b1;
      end
    end else begin
      used_n = used_q | take;
      len_n  = len_eff;
      if (tick) begin
        if (last) begin
          qc_n = '0;
          unique case (seg_q)
            SEG_SYNC: begin
              seg_n = SEG_PH1;
              len_n = timing.ts1;
            end
            SEG_PH1: begin
              seg_n = SEG_PH2;
              len_n = timing.ts2;
            end
            default: begin
              seg_n  = SEG_SYNC;
              len_n  = LEN_W'(1);
              used_n = 1'b0;
            end
          endcase
        end else begin
          qc_n = qc_q + LEN_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= SEG_IDLE;
      qc_q   <= '0;
      len_q  <= LEN_W'(1);
      used_q <= 1'b0;
      prev_q <= 1'b1;
    end else begin
      seg_q  <= seg_n;
      qc_q   <= qc_n;
      len_q  <= len_n;
      used_q <= used_n;
      prev_q <= rx_in;
    end
  end

  assign run       = (seg_q != SEG_IDLE);
  assign sample_pt = tick & (seg_q == SEG_PH1) & last;
  assign bit_end   = tick & (seg_q == SEG_PH2) & last;
endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler #(
  parameter bit EN_TRIPLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sample_pt,
  input  logic triple,
  input  logic rx_in,
  output logic rx_bit
);
  logic [1:0] hist_q, hist_n;
  logic       bit_q, bit_n;
  logic       picked;

  generate
    if (EN_TRIPLE) begin : g_vote
      logic vote;
      assign vote   = (hist_q[1] & hist_q[0]) | (hist_q[1] & rx_in) | (hist_q[0] & rx_in);
      assign picked = triple ? vote : rx_in;
    end else begin : g_single
      assign picked = rx_in;
    end
  endgenerate

  always_comb begin
    hist_n = tick ? {hist_q[0], rx_in} : hist_q;
    bit_n  = sample_pt ? picked : bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 2'b11;
      bit_q  <= 1'b1;
    end else begin
      hist_q <= hist_n;
      bit_q  <= bit_n;
    end
  end

  assign rx_bit = bit_q;
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_req,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             rx_in,
  output logic             cfg_granted,
  output logic             tq_tick,
  output logic             sample_stb,
  output logic             tx_stb,
  output logic             rx_bit
);
  logic    rst_meta_q, rst_sync_n;
  timing_t timing;
  logic    granted, run, tick, sample_pt, bit_end;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  can_bt_cfg #(.CFG_W(CFG_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_req   (cfg_req),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .granted   (granted),
    .timing    (timing)
  );

  can_bt_presc u_presc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (run),
    .brp_m1 (timing.brp_m1),
    .tick   (tick)
  );

  can_bt_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .hold      (granted),
    .tick      (tick),
    .rx_in     (rx_in),
    .timing    (timing),
    .run       (run),
    .sample_pt (sample_pt),
    .bit_end   (bit_end)
  );

  can_bt_sampler #(.EN_TRIPLE(1'b1)) u_smp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (tick),
    .sample_pt (sample_pt),
    .triple    (timing.triple),
    .rx_in     (rx_in),
    .rx_bit    (rx_bit)
  );

  assign cfg_granted = granted;
  assign tq_tick     = tick;
  assign sample_stb  = sample_pt;
  assign tx_stb      = bit_end;
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_req,
  input logic cfg_granted,
  input logic tq_tick,
  input logic sample_stb,
  input logic tx_stb,
  input logic rx_bit
);
  // R1
  grant_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |=> cfg_granted);
  // R1
  grant_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_req |=> !cfg_granted);
  // R4
  held_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_granted && $past(cfg_granted)) |-> !tq_tick);
  // R6
  strobe_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb || tx_stb) |-> tq_tick);
  // R10
  bit_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_bit) |-> $past(sample_stb));
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cfg_req     (cfg_req),
  .cfg_granted (cfg_granted),
  .tq_tick     (tq_tick),
  .sample_stb  (sample_stb),
  .tx_stb      (tx_stb),
  .rx_bit      (rx_bit)
);

// File: tb/can_bit_timer_tb.sv
module can_bit_timer_tb;
  logic        clk;
  logic        rst_n;
  logic        cfg_req;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic        rx_in;
  logic        cfg_granted, tq_tick, sample_stb, tx_stb, rx_bit;

  int n_chk;
  int n_err;
  int s_k[2];
  int x_k[2];
  int tick_n;
  logic rxlog[0:255];

  can_bit_timer #(.CFG_W(32)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_req     (cfg_req),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .rx_in       (rx_in),
    .cfg_granted (cfg_granted),
    .tq_tick     (tq_tick),
    .sample_stb  (sample_stb),
    .tx_stb      (tx_stb),
    .rx_bit      (rx_bit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] mk(int brp, int t1, int t2, int sjw, bit tri3);
    logic [31:0] v;
    v = '0;
    v[23:16] = 8'(brp - 1);
    v[9:8]   = 2'(sjw - 1);
    v[7]     = tri3;
    v[6:3]   = 4'(t1 - 1);
    v[2:0]   = 3'(t2 - 1);
    return v;
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // enter config, write, leave config (R1 checked on every pass)
  task automatic set_cfg(logic [31:0] v);
    @(negedge clk);
    rx_in   = 1'b1;
    cfg_req = 1'b1;
    @(negedge clk);
    chk("R1 grant rise", int'(cfg_granted), 1);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we  = 1'b0;
    cfg_req = 1'b0;
    @(negedge clk);
    chk("R1 grant fall", int'(cfg_granted), 0);
    @(negedge clk);
  endtask

  // hard sync at k=0, then log strobes after posedge k
  task automatic run_train(int limit, int rise_k, int fall_k);
    int ns;
    int nx;
    ns = 0;
    nx = 0;
    tick_n = 0;
    s_k[0] = -1; s_k[1] = -1;
    x_k[0] = -1; x_k[1] = -1;
    @(negedge clk);
    rx_in = 1'b0;
    for (int k = 1; k <= limit; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (sample_stb && ns < 2) begin
        s_k[ns] = k;
        ns = ns + 1;
      end
      if (tq_tick && nx == 0) tick_n++;
      if (tx_stb && nx < 2) begin
        x_k[nx] = k;
        nx = nx + 1;
      end
      rxlog[k] = rx_bit;
      if (k == rise_k) rx_in = 1'b1;
      if (k == fall_k) rx_in = 1'b0;
    end
  endtask

  task automatic t_reset;
    chk("R12 granted", int'(cfg_granted), 0);
    chk("R12 tick", int'(tq_tick), 0);
    chk("R12 sample", int'(sample_stb), 0);
    chk("R12 tx", int'(tx_stb), 0);
    chk("R12 rx_bit", int'(rx_bit), 1);
    begin
      int ticks;
      ticks = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (tq_tick) ticks++;
      end
      chk("R4 idle ticks", ticks, 0);
    end
  endtask

  task automatic t_timing(int brp, int t1, int t2, int sjw, logic [31:0] extra, string tag);
    int n;
    n = 1 + t1 + t2;
    set_cfg(mk(brp, t1, t2, sjw, 1'b0) | extra);
    run_train((2 * n + 1) * brp, -1, -1);
    chk({"R5 first sample ", tag}, s_k[0], (1 + t1) * brp);
    chk({"R6 first tx ", tag}, x_k[0], n * brp);
    chk({"R6 second sample ", tag}, s_k[1], (n + 1 + t1) * brp);
    chk({"R4 quanta per bit ", tag}, tick_n, n);
  endtask

  task automatic t_ignored_write;
    int n;
    set_cfg(mk(3, 3, 2, 1, 1'b0));
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = mk(2, 6, 4, 2, 1'b0);
    @(negedge clk);
    cfg_we = 1'b0;
    n = 6;
    run_train((2 * n + 1) * 3, -1, -1);
    chk("R2 ignored write sample", s_k[0], 4 * 3);
    chk("R2 ignored write tx", x_k[0], n * 3);
  endtask

  task automatic t_late(int d);
    int n;
    int e;
    n = 11;
    e = imin(d, 2);
    set_cfg(mk(2, 6, 4, 2, 1'b0));
    run_train((2 * n + 4) * 2, 2, (n + d) * 2 + 1);
    chk($sformatf("R7 late %0d sample", d), s_k[1], (n + 1 + 6 + e) * 2);
    chk($sformatf("R7 late %0d tx", d), x_k[1], (2 * n + e) * 2);
  endtask

  task automatic t_early(int d);
    int n;
    int s;
    n = 11;
    s = imin(d, 2);
    set_cfg(mk(2, 6, 4, 2, 1'b0));
    run_train((2 * n + 1) * 2, 2, (2 * n - 1 - d) * 2 + 1);
    chk($sformatf("R8 early %0d sample", d), s_k[1], (n + 1 + 6) * 2);
    chk($sformatf("R8 early %0d tx", d), x_k[1], (2 * n - s) * 2);
  endtask

  task automatic t_once;
    int n;
    n = 11;
    set_cfg(mk(2, 6, 4, 2, 1'b0));
    run_train((n + 1) * 2, 2, 3 * 2 + 1);
    chk("R9 hard-sync bit sample", s_k[0], 7 * 2);
    chk("R9 hard-sync bit tx", x_k[0], n * 2);
    set_cfg(mk(2, 6, 4, 2, 1'b0));
    run_train((2 * n + 1) * 2, 2, n * 2 + 1);
    chk("R9 sync quantum edge", s_k[1], (n + 1 + 6) * 2);
  endtask

  task automatic t_sampling;
    // brp 4: triple bit set but not honoured
    set_cfg(mk(4, 4, 3, 1, 1'b1));
    run_train(24, 11, 17);
    chk("R10 single low", int'(rxlog[21]), 0);
    set_cfg(mk(4, 4, 3, 1, 1'b1));
    run_train(24, 17, -1);
    chk("R11 brp4 single high", int'(rxlog[21]), 1);
    // brp 5 with triple: majority
    set_cfg(mk(5, 4, 3, 1, 1'b1));
    run_train(30, 14, 21);
    chk("R11 vote high", int'(rxlog[26]), 1);
    set_cfg(mk(5, 4, 3, 1, 1'b1));
    run_train(30, 21, -1);
    chk("R11 vote low", int'(rxlog[26]), 0);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk     = 0;
    n_err     = 0;
    rst_n     = 1'b0;
    cfg_req   = 1'b0;
    cfg_we    = 1'b0;
    cfg_wdata = '0;
    rx_in     = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_timing(2, 6, 4, 2, 32'h0, "A");
    t_timing(1, 16, 8, 4, 32'h0, "C");
    t_timing(8, 5, 3, 1, 32'h0, "D");
    // R3 unused bits set must not matter
    t_timing(3, 3, 2, 1, 32'hFF00_FC00, "B");
    t_ignored_write();
    for (int d = 1; d <= 3; d++) t_late(d);
    for (int d = 1; d <= 3; d++) t_early(d);
    t_once();
    t_sampling();
    finish_run();
  end
endmodule